// File: doc/BRIEF.md
# Pixel-to-Symbol Color-Depth Gearbox

This block sits in the link clock domain, just after the clock-crossing FIFO. It takes one pixel per accepted transfer and turns it into a gap-free stream of 8-bit link symbols. Each pixel carries three color components. Each component is held in its own fixed-width field of the input word. A static depth select decides how many low bits of each field are significant. The block concatenates those bits component by component, most significant bit first. It slices the resulting bit stream into bytes. Bits that do not yet fill a byte stay in a residue accumulator until the next pixel arrives.

An end-of-line flag on the last pixel of a video line makes the block flush the residue, padding with zeros up to the next byte boundary. Input is refused until that line has fully drained. Downstream back-pressure is honoured through a valid/ready pair on each side, and no bit is lost or repeated.

Depths of 6 and 8 bits per component are always built. The 10-bit variant is an elaboration-time option. When it is turned off, its packing logic is not generated at all.

Top module: `pix_sym_gearbox`

## Requirements
- R1: `depth_sel` code 0 selects 6 bits per component, code 1 selects 8, and code 2 selects 10 when the 10-bit variant is enabled. Code 3, and code 2 with the variant disabled, both select 8.
- R2: `in_pix` holds three MAX_BPC-bit fields. The field at bits [3*MAX_BPC-1:2*MAX_BPC] is sent first, then [2*MAX_BPC-1:MAX_BPC], then [MAX_BPC-1:0]. Within each field only the low depth bits are used, most significant first, and the upper bits of the field have no effect on the output.
- R3: Output symbols are consecutive 8-bit groups of that bit stream, with the first bit in `out_sym[7]`. Pixels of one line are packed with no padding between them, so four pixels at 6 bits give exactly 9 symbols.
- R4: At 8 bits per component, every pixel yields exactly 3 symbols, equal to its three components in field order.
- R5: A pixel accepted with `in_eol` high ends the line. The residue is padded with zeros to a byte boundary, so a line of n pixels at depth b gives ceil(3*n*b/8) symbols. A 640-pixel line at 6 bits gives 1440 symbols.
- R6: After a pixel with `in_eol` is accepted, `in_ready` stays low until the last symbol of that line has been taken.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low. On the next cycle `out_valid` is still high and `out_sym` is unchanged.
- R8: With pixels offered on every cycle and `out_ready` held high, `out_valid` has no low cycle between the first and last symbol of a line.
- R9: In the cycle after `rst_n` is sampled low, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Synchronous reset, active low |
| depth_sel | input | 2 | Component depth code (static while traffic flows) |
| in_valid | input | 1 | Pixel word offered |
| in_ready | output | 1 | Pixel word accepted when high together with `in_valid` |
| in_pix | input | 3*MAX_BPC | Three component fields |
| in_eol | input | 1 | Marks the last pixel of a line |
| out_valid | output | 1 | Symbol available |
| out_ready | input | 1 | Downstream takes the symbol |
| out_sym | output | 8 | Link symbol |

## Verification
The assertions assume that `depth_sel` changes only while the accumulator is empty and no line is pending. They also assume that the upstream holds `in_pix` and `in_eol` steady while it waits for `in_ready`. The bench writes `depth_sel` only between cases, after every expected symbol of the previous case has been drained. It presents each pixel until the handshake completes. Back-pressure comes from a deterministic shift-register pattern on `out_ready`. The sweep covers every depth code, lines of several lengths, and one full 640-pixel line, with the expected symbols derived from a bit-level model of the packing rule.

// File: rtl/gbx_pkg.sv
// Shared definitions for the pixel-to-symbol gearbox.
// Assumes three color components per pixel and 8-bit link symbols.
package gbx_pkg;
    localparam int NUM_COMP = 3;
    localparam int SYM_W    = 8;

    typedef enum logic [1:0] {
        DEPTH_6   = 2'd0,
        DEPTH_8   = 2'd1,
        DEPTH_10  = 2'd2,
        DEPTH_RSV = 2'd3
    } depth_e;
endpackage

// File: rtl/gbx_depth_dec.sv
// Decodes the static depth code into a one-hot variant select and the
// number of payload bits per pixel. Codes that name a variant not built
// fall back to 8 bits per component.
module gbx_depth_dec
    import gbx_pkg::*;
#(
    parameter bit EN_BPC10 = 1'b1,
    parameter int CNT_W    = 6
) (
    input  logic [1:0]       depth_sel,
    output logic [2:0]       sel_oh,    // {10, 8, 6}
    output logic [CNT_W-1:0] nbits
);
    // Map the code to a variant and its bits per pixel.
    always_comb begin
        sel_oh = 3'b010;
        nbits  = CNT_W'(NUM_COMP * 8);
        case (depth_e'(depth_sel))
            DEPTH_6: begin
                sel_oh = 3'b001;
                nbits  = CNT_W'(NUM_COMP * 6);
            end
            DEPTH_10: begin
                if (EN_BPC10) begin
                    sel_oh = 3'b100;
                    nbits  = CNT_W'(NUM_COMP * 10);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/gbx_pack.sv
// Extracts the low BPC bits of each of the three component fields and
// concatenates them, first field on top, zero-extended to PW bits.
// Assumes BPC <= MAX_BPC.
module gbx_pack #(
    parameter int BPC     = 8,
    parameter int MAX_BPC = 10,
    parameter int PW      = 30
) (
    input  logic [PW-1:0] in_pix,
    output logic [PW-1:0] packed_o
);
    // Right-aligned concatenation of the significant bits.
    assign packed_o = PW'({in_pix[2*MAX_BPC +: BPC],
                           in_pix[MAX_BPC   +: BPC],
                           in_pix[0         +: BPC]});
endmodule

// File: rtl/gbx_accum.sv
// Residue accumulator: holds valid bits left-aligned, emits a byte once
// 8 bits are present, or a zero-padded partial byte while a line flush
// is pending. Accepts new bits only if at most 7 bits remain after this
// cycle's pop. Assumes bits_in is zero above nbits and that nbits
// does not exceed ACC_W-8.
module gbx_accum
    import gbx_pkg::*;
#(
    parameter int PW    = 30,
    parameter int ACC_W = 38,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PW-1:0]    bits_in,
    input  logic [CNT_W-1:0] nbits,
    input  logic             in_valid,
    input  logic             in_eol,
    output logic             in_ready,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [SYM_W-1:0] out_sym
);
    localparam logic [CNT_W-1:0] ONE_SYM = CNT_W'(SYM_W);
    localparam logic [CNT_W-1:0] TWO_SYM = CNT_W'(2 * SYM_W);

    logic [ACC_W-1:0] acc_q, acc_p, acc_d;
    logic [CNT_W-1:0] cnt_q, cnt_p, cnt_d, shamt;
    logic             pad_q, pad_d;
    logic             pop, push;

    // Handshakes and the next accumulator state.
    always_comb begin
        out_valid = (cnt_q >= ONE_SYM) || (pad_q && (cnt_q != '0));
        out_sym   = acc_q[ACC_W-1 -: SYM_W];
        in_ready  = !pad_q && ((cnt_q < ONE_SYM) || ((cnt_q < TWO_SYM) && out_ready));
        pop       = out_valid && out_ready;
        push      = in_valid && in_ready;
        acc_p     = pop ? (acc_q << SYM_W) : acc_q;
        cnt_p     = pop ? ((cnt_q >= ONE_SYM) ? (cnt_q - ONE_SYM) : '0) : cnt_q;
        shamt     = CNT_W'(ACC_W) - cnt_p - nbits;
        acc_d     = push ? (acc_p | (ACC_W'(bits_in) << shamt)) : acc_p;
        cnt_d     = push ? (cnt_p + nbits) : cnt_p;
        pad_d     = pad_q;
        if (push && in_eol)
            pad_d = 1'b1;
        else if (pop && (cnt_p == '0))
            pad_d = 1'b0;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
            pad_q <= 1'b0;
        end else begin
            acc_q <= acc_d;
            cnt_q <= cnt_d;
            pad_q <= pad_d;
        end
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_sym))); // R7
    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> ((cnt_p + nbits) <= CNT_W'(ACC_W))); // R7
    AST_EOL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_eol) |=> !in_ready); // R6
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready)); // R9
endmodule

// File: rtl/pix_sym_gearbox.sv
// Top of the color-depth gearbox. Builds one packer per enabled depth,
// selects the active one from the static depth code and feeds the
// residue accumulator. Assumes depth_sel only changes while idle.
module pix_sym_gearbox
    import gbx_pkg::*;
#(
    parameter int MAX_BPC  = 10,
    parameter bit EN_BPC10 = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                depth_sel,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic [NUM_COMP*MAX_BPC-1:0] in_pix,
    input  logic                      in_eol,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic [SYM_W-1:0]          out_sym
);
    localparam int PW    = NUM_COMP * MAX_BPC;
    localparam int ACC_W = PW + SYM_W;
    localparam int CNT_W = $clog2(ACC_W + 1);

    logic [2:0]       sel_oh;
    logic [CNT_W-1:0] nbits;
    logic [PW-1:0]    p6, p8, p10, bits_sel;

    gbx_depth_dec #(.EN_BPC10(EN_BPC10), .CNT_W(CNT_W)) u_dec (
        .depth_sel(depth_sel), .sel_oh(sel_oh), .nbits(nbits)
    );

    gbx_pack #(.BPC(6), .MAX_BPC(MAX_BPC), .PW(PW)) u_pack6 (
        .in_pix(in_pix), .packed_o(p6)
    );
    gbx_pack #(.BPC(8), .MAX_BPC(MAX_BPC), .PW(PW)) u_pack8 (
        .in_pix(in_pix), .packed_o(p8)
    );

    generate
        if (EN_BPC10) begin : g_bpc10
            gbx_pack #(.BPC(10), .MAX_BPC(MAX_BPC), .PW(PW)) u_pack10 (
                .in_pix(in_pix), .packed_o(p10)
            );
        end else begin : g_no_bpc10
            assign p10 = '0;
        end
    endgenerate

    // AND-OR select of the active packer output.
    always_comb begin
        bits_sel = ({PW{sel_oh[0]}} & p6) | ({PW{sel_oh[1]}} & p8) | ({PW{sel_oh[2]}} & p10);
    end

    gbx_accum #(.PW(PW), .ACC_W(ACC_W), .CNT_W(CNT_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .bits_in(bits_sel), .nbits(nbits),
        .in_valid(in_valid), .in_eol(in_eol), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym)
    );

    AST_ONE_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_oh) == 1); // R1
    AST_DEPTH_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (nbits == 6'd18) || (nbits == 6'd24) || (EN_BPC10 && nbits == 6'd30)); // R1
endmodule

// File: tb/pix_sym_gearbox_tb.sv
`timescale 1ns/1ps
module pix_sym_gearbox_tb;
    localparam int MB = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  depth_sel = 2'd0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [29:0] in_pix = '0;
    logic        in_eol = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_sym;

    int total = 0;
    int bad   = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [29:0] pix_mem [640];
    bit          eol_mem [640];
    int          end_mem [640];
    bit          bq[$];
    logic [7:0]  exp_q[$];

    always #2.5 clk = ~clk;

    pix_sym_gearbox u_dut (
        .clk(clk), .rst_n(rst_n), .depth_sel(depth_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready), .out_sym(out_sym)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int dsel, input int n, input int eol_every,
                            input bit stall, input bit chk_gap, input int exp_total,
                            input string req);
        int  b, popped, pi, last_end, gaps, iter;
        bit  prev_stall;
        logic [7:0] prev_sym;
        b = (dsel == 0) ? 6 : (dsel == 2) ? 10 : 8;
        bq.delete();
        exp_q.delete();
        for (int p = 0; p < n; p++) begin
            for (int c = 0; c < 3; c++)
                pix_mem[p][(2-c)*MB +: MB] = 10'((p*97 + c*331 + dsel*53 + 17) & 10'h3FF);
            for (int c = 0; c < 3; c++)
                for (int i = b-1; i >= 0; i--)
                    bq.push_back(pix_mem[p][(2-c)*MB + i]);
            eol_mem[p] = (((p+1) % eol_every) == 0) || (p == n-1);
            if (eol_mem[p])
                while ((bq.size() % 8) != 0) bq.push_back(1'b0);
            end_mem[p] = bq.size() / 8;
        end
        for (int k = 0; k < bq.size() / 8; k++) begin
            logic [7:0] v;
            for (int i = 0; i < 8; i++) v[7-i] = bq[k*8+i];
            exp_q.push_back(v);
        end
        check(exp_q.size() == exp_total, {req, " model count"}, exp_q.size(), exp_total);
        depth_sel = 2'(dsel);
        popped = 0; pi = 0; last_end = 0; gaps = 0; iter = 0; prev_stall = 0; prev_sym = '0;
        while ((popped < exp_q.size()) && (iter < 20000)) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = stall ? lfsr[0] | lfsr[3] : 1'b1;
            in_valid  = (pi < n);
            in_pix    = (pi < n) ? pix_mem[pi] : '0;
            in_eol    = (pi < n) ? eol_mem[pi] : 1'b0;
            #1;
            if (prev_stall)
                check(out_valid && (out_sym == prev_sym), "R7 hold", int'(out_sym), int'(prev_sym));
            if (out_valid && !out_ready)
                check(!in_ready, "R7 input blocked", int'(in_ready), 0);
            if (popped < last_end)
                check(!in_ready, "R6 flush blocks input", int'(in_ready), 0);
            if (chk_gap && popped > 0 && !out_valid) gaps++;
            if (out_valid && out_ready) begin
                check(out_sym == exp_q[popped], req, int'(out_sym), int'(exp_q[popped]));
                popped++;
            end
            if (in_valid && in_ready) begin
                if (in_eol) last_end = end_mem[pi];
                pi++;
            end
            prev_stall = out_valid && !out_ready;
            prev_sym   = out_sym;
            iter++;
        end
        in_valid = 1'b0;
        check(popped == exp_total, {req, " symbol count"}, popped, exp_total);
        if (chk_gap) check(gaps == 0, "R8 no bubbles", gaps, 0);
        @(negedge clk);
        out_ready = 1'b1;
        #1;
        check(!out_valid, {req, " drained"}, int'(out_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check(!out_valid, "R9 out_valid after reset", int'(out_valid), 0);
        check(in_ready, "R9 in_ready after reset", int'(in_ready), 1);
        rst_n = 1'b1;
        // R3: 4 pixels at 6 bits -> 9 symbols; also R8 continuous flow
        run_case(0, 4, 100, 1'b0, 1'b1, 9, "R3/R2 6bpc");
        // R4: 8 bits per component, 3 symbols per pixel
        run_case(1, 5, 100, 1'b0, 1'b1, 15, "R4 8bpc");
        // R1: code 2 is 10 bits, several lines, back-pressure (R5, R6, R7)
        run_case(2, 7, 3, 1'b1, 1'b0, 28, "R1/R5 10bpc");
        // R1: reserved code 3 behaves as 8 bits
        run_case(3, 4, 100, 1'b1, 1'b0, 12, "R1/R4 code3");
        // R5: one fail-safe 640-pixel line at 6 bits
        run_case(0, 640, 1000, 1'b1, 1'b0, 1440, "R5 640 line");
        // R5: 5 pixels at 6 bits -> 90 bits padded to 12 symbols
        run_case(0, 5, 5, 1'b0, 1'b1, 12, "R5 pad 6bpc");
        // R8: 10 bits with no stalls, 180 bits -> 23 symbols
        run_case(2, 6, 100, 1'b0, 1'b1, 23, "R8/R5 10bpc");
        // R6: short lines of 2 pixels at 6 bits under stalls
        run_case(0, 9, 2, 1'b1, 1'b0, 23, "R6/R5 short lines");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule